// File: doc/BRIEF.md
# Burst Address Counter with Load Strobe

This unit sits in front of one port of a synchronous memory and decides, at every rising clock edge, which address that port uses for the cycle. There are four sources, in fixed priority. The counter can be cleared to zero. An externally presented address can be captured. The previously used address can be kept. The previously used address can be stepped by one. The chosen address is registered and drives the memory for the cycle. It also becomes the base that the next cycle holds or steps from.

Three active-low controls select the source: a counter clear, an address load strobe and a count enable. Clear wins over load, and load wins over hold and step. The controls do not depend on any chip or byte select, so the counter keeps stepping in cycles where the memory is deselected. A clear costs no extra cycle, because the access in the clearing cycle already uses address zero. Driving the strobe low on every edge gives fully random addressing. A burst runs by loading once and then enabling the count. A small one-hot flag vector reports which source was taken in the current cycle.

Top module: `acu_burst_counter`

## Requirements
- R1: With cnt_clr_n_i low at a clock edge, addr_o after that edge is 0, whatever load_n_i and cnt_en_n_i are.
- R2: With cnt_clr_n_i high and load_n_i low at an edge, addr_o after that edge equals the ext_addr_i sampled at that edge, whatever cnt_en_n_i is.
- R3: With cnt_clr_n_i, load_n_i and cnt_en_n_i all high at an edge, addr_o keeps its previous value.
- R4: With cnt_clr_n_i and load_n_i high and cnt_en_n_i low at an edge, addr_o becomes its previous value plus one.
- R5: Stepping from the all-ones address gives 0.
- R6: Out of reset, mode_o is one-hot after every edge: bit 0 = clear, bit 1 = load, bit 2 = hold, bit 3 = step.
- R7: While rst_n is low at an edge (synchronous reset), addr_o becomes 0 and mode_o becomes 4'b0000. A later hold keeps 0.
- R8: A new address loaded on every consecutive edge is used at once, with no dead cycle. A step in the cycle after a load counts from the loaded address.
- R9: A step in the cycle right after a clear gives address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| ext_addr_i | input | AW | External address, captured when the strobe is low |
| load_n_i | input | 1 | Active-low address load strobe |
| cnt_en_n_i | input | 1 | Active-low count enable |
| cnt_clr_n_i | input | 1 | Active-low counter clear |
| addr_o | output | AW | Address used in the current cycle |
| mode_o | output | 4 | One-hot source flags: clear, load, hold, step |

## Verification
The bench drives all three controls at once, to test priority. A clear with the strobe and enable also low must still give zero; a design that let load or count win would show the external address or base plus one. Steps from the all-ones address must give zero, so a counter that saturated or carried into a wider register is caught. Back-to-back loads followed directly by a step expose any design that steps from a stale base or inserts a dead cycle. A synchronous reset in the middle of a run, followed by a hold, shows whether the stored base was actually cleared.

// File: rtl/acu_pkg.sv
package acu_pkg;

    localparam int unsigned NUM_SRC = 4;

    typedef enum logic [1:0] {
        SRC_CLEAR = 2'd0,
        SRC_LOAD  = 2'd1,
        SRC_HOLD  = 2'd2,
        SRC_STEP  = 2'd3
    } src_e;

endpackage

// File: rtl/acu_src_sel.sv
module acu_src_sel
    import acu_pkg::*;
(
    input  logic clr_n,
    input  logic load_n,
    input  logic cnt_en_n,
    output src_e src
);

    // Fixed priority: clear, then load, then hold/step.
    always_comb begin
        if (!clr_n) begin
            src = SRC_CLEAR;
        end else if (!load_n) begin
            src = SRC_LOAD;
        end else if (cnt_en_n) begin
            src = SRC_HOLD;
        end else begin
            src = SRC_STEP;
        end
    end

endmodule

// File: rtl/acu_next_addr.sv
module acu_next_addr
    import acu_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  src_e          src,
    input  logic [AW-1:0] ext_addr,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] nxt
);

    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] incr;

    // Modulo increment: all-ones wraps to zero.
    assign incr = base + ONE;

    always_comb begin
        unique case (src)
            SRC_CLEAR: nxt = '0;
            SRC_LOAD:  nxt = ext_addr;
            SRC_HOLD:  nxt = base;
            SRC_STEP:  nxt = incr;
            default:   nxt = base;
        endcase
    end

endmodule

// File: rtl/acu_mode_flags.sv
module acu_mode_flags
    import acu_pkg::*;
(
    input  src_e               src,
    output logic [NUM_SRC-1:0] flags
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
        assign flags[g] = (src == src_e'(g));
    end

endmodule

// File: rtl/acu_burst_counter.sv
module acu_burst_counter
    import acu_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      ext_addr_i,
    input  logic               load_n_i,
    input  logic               cnt_en_n_i,
    input  logic               cnt_clr_n_i,
    output logic [AW-1:0]      addr_o,
    output logic [NUM_SRC-1:0] mode_o
);

    typedef struct packed {
        logic [AW-1:0]      addr;
        logic [NUM_SRC-1:0] mode;
    } state_t;

    state_t state_d, state_q;

    src_e               src;
    logic [AW-1:0]      nxt_addr;
    logic [NUM_SRC-1:0] nxt_mode;

    acu_src_sel u_sel (
        .clr_n    (cnt_clr_n_i),
        .load_n   (load_n_i),
        .cnt_en_n (cnt_en_n_i),
        .src      (src)
    );

    acu_next_addr #(.AW(AW)) u_next (
        .src      (src),
        .ext_addr (ext_addr_i),
        .base     (state_q.addr),
        .nxt      (nxt_addr)
    );

    acu_mode_flags u_flags (
        .src   (src),
        .flags (nxt_mode)
    );

    always_comb begin
        state_d      = state_q;
        state_d.addr = nxt_addr;
        state_d.mode = nxt_mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign addr_o = state_q.addr;
    assign mode_o = state_q.mode;

endmodule

// File: rtl/acu_burst_counter_chk.sv
module acu_burst_counter_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] ext_addr_i,
    input logic          load_n_i,
    input logic          cnt_en_n_i,
    input logic          cnt_clr_n_i,
    input logic [AW-1:0] addr_o,
    input logic [3:0]    mode_o
);

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr_n_i |=> (addr_o == '0)); // R1

    AST_LOAD_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr_n_i && !load_n_i) |=> (addr_o == $past(ext_addr_i))); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr_n_i && load_n_i && cnt_en_n_i) |=> $stable(addr_o)); // R3

    AST_STEP_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr_n_i && load_n_i && !cnt_en_n_i) |=> (addr_o == AW'($past(addr_o) + AW'(1)))); // R4

    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $onehot(mode_o)); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (addr_o == '0 && mode_o == 4'b0000)); // R7

endmodule

bind acu_burst_counter acu_burst_counter_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_addr_i  (ext_addr_i),
    .load_n_i    (load_n_i),
    .cnt_en_n_i  (cnt_en_n_i),
    .cnt_clr_n_i (cnt_clr_n_i),
    .addr_o      (addr_o),
    .mode_o      (mode_o)
);

// File: tb/acu_burst_counter_tb.sv
module acu_burst_counter_tb;

    localparam int unsigned AW      = 16;
    localparam time         CLK_PER = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr_i = '0;
    logic          load_n_i = 1'b1;
    logic          cnt_en_n_i = 1'b1;
    logic          cnt_clr_n_i = 1'b1;
    logic [AW-1:0] addr_o;
    logic [3:0]    mode_o;

    acu_burst_counter #(.AW(AW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_addr_i  (ext_addr_i),
        .load_n_i    (load_n_i),
        .cnt_en_n_i  (cnt_en_n_i),
        .cnt_clr_n_i (cnt_clr_n_i),
        .addr_o      (addr_o),
        .mode_o      (mode_o)
    );

    always #(CLK_PER/2) clk = ~clk;

    typedef struct {
        logic [AW-1:0] addr;
        logic [3:0]    mode;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    logic [AW-1:0] base = '0;
    int            checks = 0;
    int            errors = 0;
    bit            done = 0;

    task automatic check_val(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of controls and pushes the expected result.
    task automatic drive(input bit clr_n, input bit ld_n, input bit en_n,
                         input logic [AW-1:0] ext, input string tag);
        exp_t e;
        @(negedge clk);
        cnt_clr_n_i = clr_n;
        load_n_i    = ld_n;
        cnt_en_n_i  = en_n;
        ext_addr_i  = ext;
        if (!clr_n) begin
            e.addr = '0;        e.mode = 4'b0001;
        end else if (!ld_n) begin
            e.addr = ext;       e.mode = 4'b0010;
        end else if (en_n) begin
            e.addr = base;      e.mode = 4'b0100;
        end else begin
            e.addr = base + 1'b1; e.mode = 4'b1000;
        end
        base  = e.addr;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compares a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PER/4);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check_val(e.tag, addr_o, e.addr);
                check_val("R6 mode", AW'(mode_o), AW'(e.mode));
            end
        end
    end

    initial begin
        #(CLK_PER * 5000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R7: reset state
        repeat (3) @(posedge clk);
        #(CLK_PER/4);
        check_val("R7 reset addr", addr_o, '0);
        check_val("R7 reset mode", AW'(mode_o), '0);
        @(negedge clk);
        rst_n = 1'b1;

        drive(1, 0, 1, 16'h1234, "R2 load");
        drive(1, 1, 0, 16'h0000, "R4 step");
        drive(1, 1, 0, 16'hAAAA, "R4 step");
        drive(1, 1, 1, 16'h5555, "R3 hold");
        drive(1, 1, 1, 16'h0F0F, "R3 hold");
        drive(1, 0, 0, 16'h7777, "R2 load with enable low");
        drive(0, 0, 0, 16'h4321, "R1 clear over load and step");
        drive(1, 1, 0, 16'h9999, "R9 step after clear");
        drive(0, 1, 1, 16'h1111, "R1 clear alone");
        drive(1, 0, 1, 16'hFFFE, "R2 load near top");
        drive(1, 1, 0, 16'h0000, "R5 step to all ones");
        drive(1, 1, 0, 16'h0000, "R5 wrap to zero");
        drive(1, 1, 0, 16'h0000, "R5 step after wrap");
        drive(1, 0, 1, 16'h0400, "R8 load a");
        drive(1, 0, 1, 16'h8001, "R8 load b");
        drive(1, 0, 0, 16'h3C3C, "R8 load c");
        drive(1, 0, 1, 16'hFFFF, "R8 load d");
        drive(1, 0, 1, 16'h0123, "R8 load e");
        drive(1, 1, 0, 16'hDEAD, "R8 step from loaded");
        drive(1, 1, 1, 16'hBEEF, "R3 hold after step");

        // R7: synchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        wait (sb_q.size() == 0);
        @(posedge clk);
        #(CLK_PER/4);
        check_val("R7 mid-run reset addr", addr_o, '0);
        check_val("R7 mid-run reset mode", AW'(mode_o), '0);
        @(negedge clk);
        rst_n = 1'b1;
        base  = '0;
        drive(1, 1, 1, 16'h2222, "R7 hold after reset");
        drive(1, 1, 0, 16'h3333, "R4 step after reset");

        wait (sb_q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule